// File: doc/BRIEF.md
# Luma Peaking and Coring Stage

This stage sharpens a stream of signed 8-bit luma samples. A short symmetric FIR extracts a high-frequency detail term from a five-sample window. A coring step removes small detail values, which are mostly noise. The surviving detail is scaled by a selectable power-of-two gain and added to a main luma sample taken from the same window. The sum saturates to a signed 9-bit result, because peaking can push the value past the 8-bit input range.

A two-bit trim field picks which window tap feeds the main path. This moves luma by -2, -1, 0 or +1 samples relative to the nominal two-sample delay, so that luma can be aligned with a chroma path that runs beside it. The window advances only on cycles that carry a valid sample. Every accepted sample yields exactly one output sample.

Top module: `luma_peaking_core`

## Requirements
- R1: While reset is high and after it is released, `out_valid` is 0 and `out_luma` is 0 until the first output is produced. The sample window also clears to zero.
- R2: `out_valid` is high in the cycle two clock edges after a cycle with `in_valid` high, and is low otherwise.
- R3: Cycles with `in_valid` low do not shift the window and do not change `out_luma`, which holds its last value.
- R4: In the window s0 (newest) to s4, let e1 = 2*s2-s1-s3, e2 = 2*s2-s0-s4 and e4 = 4*s2-s0-s1-s3-s4. With `cfg_bypass`=0 the detail term d depends on `cfg_band`: 0 gives e1>>>1, 1 gives e2>>>1, 2 gives e4>>>2, 3 gives e1. Here >>> is an arithmetic (floor) shift.
- R5: With `cfg_bypass`=1, `cfg_band` is ignored. `cfg_alt`=0 gives d = e2>>>2 and `cfg_alt`=1 gives d = e4>>>3.
- R6: `cfg_core` sets the coring threshold T: 0 gives 0, 1 gives 2, 2 gives 4, 3 gives 8. If |d| <= T the cored term is 0; otherwise it equals d unchanged.
- R7: The gain code {`cfg_bypass`,`cfg_gain`} scales the cored term by an arithmetic right shift: 000 shifts by 3, 001 by 2, 010 by 1, 011 by 0, 100 forces 0 (peaking off), 101 shifts by 2, 110 by 1, 111 by 0.
- R8: `cfg_trim` picks the main sample: 0 gives s2, 1 gives s3 (one sample later), 2 gives s0 (two samples earlier), 3 gives s1 (one sample earlier).
- R9: The output is clamped to the range -256 to 255.
- R10: The output equals the main sample plus the scaled term, subject to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_luma | input | 8 | Signed luma sample |
| cfg_band | input | 2 | Detail kernel select when not bypassed |
| cfg_bypass | input | 1 | Bypass the primary kernels; also the MSB of the gain code |
| cfg_alt | input | 1 | Alternative response select when bypassed |
| cfg_gain | input | 2 | Low bits of the gain code |
| cfg_core | input | 2 | Coring threshold select |
| cfg_trim | input | 2 | Luma alignment trim |
| out_valid | output | 1 | Output sample qualifier |
| out_luma | output | 9 | Signed sharpened luma |

## Verification
The hardest case to reach from the ports is a window that has frozen over gaps in `in_valid`. Here the output must come from the five accepted samples, not from the last five clock cycles, and it must hold steady across the idle cycles. The stimulus inserts random invalid cycles into most sample runs. It then sweeps every combination of kernel, bypass response, gain code, coring level and trim. Sample sets are chosen to push the detail term across each coring threshold, into 9-bit saturation at both ends, and across sharp steps.

// File: rtl/luma_pk_pkg.sv
package luma_pk_pkg;

    localparam int PIX_W = 8;
    localparam int OUT_W = PIX_W + 1;
    localparam int ACC_W = PIX_W + 4;
    localparam int TAPS  = 5;
    localparam int MID   = TAPS / 2;
    localparam int OUT_MAX = (1 << (OUT_W - 1)) - 1;
    localparam int OUT_MIN = -(1 << (OUT_W - 1));

    typedef logic signed [PIX_W-1:0] pix_t;
    typedef logic signed [OUT_W-1:0] out_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        CORE_OFF   = 2'd0,
        CORE_SMALL = 2'd1,
        CORE_MED   = 2'd2,
        CORE_HIGH  = 2'd3
    } core_e;

    typedef enum logic [1:0] {
        TRIM_ZERO   = 2'd0,
        TRIM_LATE1  = 2'd1,
        TRIM_EARLY2 = 2'd2,
        TRIM_EARLY1 = 2'd3
    } trim_e;

    typedef struct packed {
        logic [1:0] band;
        logic       bypass;
        logic       alt;
        logic [1:0] gain;
        core_e      core;
        trim_e      trim;
    } cfg_t;

    function automatic acc_t core_thr(input core_e c);
        case (c)
            CORE_OFF:   return acc_t'(0);
            CORE_SMALL: return acc_t'(2);
            CORE_MED:   return acc_t'(4);
            default:    return acc_t'(8);
        endcase
    endfunction

    function automatic logic [1:0] gain_shift(input logic [2:0] code);
        case (code)
            3'b000:  return 2'd3;
            3'b001:  return 2'd2;
            3'b010:  return 2'd1;
            3'b101:  return 2'd2;
            3'b110:  return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic out_t sat_out(input acc_t v);
        if (v > acc_t'(OUT_MAX))      return out_t'(OUT_MAX);
        else if (v < acc_t'(OUT_MIN)) return out_t'(OUT_MIN);
        else                          return v[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/lpk_window.sv
module lpk_window
    import luma_pk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  pix_t in_pix,
    output pix_t taps [TAPS]
);

    pix_t tap_q [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)           tap_q[i] <= '0;
                else if (in_valid) tap_q[i] <= in_pix;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)           tap_q[i] <= '0;
                else if (in_valid) tap_q[i] <= tap_q[i-1];
            end
        end
        assign taps[i] = tap_q[i];
    end

    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(tap_q[0]) && $stable(tap_q[TAPS-1]))); // R3

endmodule

// File: rtl/lpk_bandpass.sv
module lpk_bandpass
    import luma_pk_pkg::*;
(
    input  pix_t       taps [TAPS],
    input  logic [1:0] band,
    input  logic       bypass,
    input  logic       alt,
    output acc_t       detail
);

    acc_t s0, s1, s2, s3, s4;
    acc_t e1, e2, e4;

    always_comb begin
        s0 = acc_t'(taps[0]);
        s1 = acc_t'(taps[1]);
        s2 = acc_t'(taps[MID]);
        s3 = acc_t'(taps[3]);
        s4 = acc_t'(taps[4]);
        e1 = (s2 <<< 1) - s1 - s3;
        e2 = (s2 <<< 1) - s0 - s4;
        e4 = (s2 <<< 2) - s0 - s1 - s3 - s4;
        if (bypass) begin
            detail = alt ? (e4 >>> 3) : (e2 >>> 2);
        end else begin
            case (band)
                2'd0:    detail = e1 >>> 1;
                2'd1:    detail = e2 >>> 1;
                2'd2:    detail = e4 >>> 2;
                default: detail = e1;
            endcase
        end
    end

endmodule

// File: rtl/lpk_coring.sv
module lpk_coring
    import luma_pk_pkg::*;
(
    input  acc_t  detail,
    input  core_e level,
    output acc_t  cored
);

    acc_t mag;

    always_comb begin
        mag   = detail[ACC_W-1] ? -detail : detail;
        cored = (mag <= core_thr(level)) ? acc_t'(0) : detail;
    end

endmodule

// File: rtl/luma_peaking_core.sv
module luma_peaking_core
    import luma_pk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_luma,
    input  logic [1:0]       cfg_band,
    input  logic             cfg_bypass,
    input  logic             cfg_alt,
    input  logic [1:0]       cfg_gain,
    input  logic [1:0]       cfg_core,
    input  logic [1:0]       cfg_trim,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_luma
);

    cfg_t cfg;
    pix_t taps [TAPS];
    acc_t detail, cored, scaled, sum;
    pix_t main_pix;
    logic v1_q, ov_q;
    out_t out_q;
    logic [2:0] gcode;

    always_comb begin
        cfg.band   = cfg_band;
        cfg.bypass = cfg_bypass;
        cfg.alt    = cfg_alt;
        cfg.gain   = cfg_gain;
        cfg.core   = core_e'(cfg_core);
        cfg.trim   = trim_e'(cfg_trim);
    end

    lpk_window u_win (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_pix   (pix_t'(in_luma)),
        .taps     (taps)
    );

    lpk_bandpass u_bp (
        .taps   (taps),
        .band   (cfg.band),
        .bypass (cfg.bypass),
        .alt    (cfg.alt),
        .detail (detail)
    );

    lpk_coring u_core (
        .detail (detail),
        .level  (cfg.core),
        .cored  (cored)
    );

    always_comb begin
        gcode  = {cfg.bypass, cfg.gain};
        scaled = (gcode == 3'b100) ? acc_t'(0) : (cored >>> gain_shift(gcode));
        case (cfg.trim)
            TRIM_ZERO:   main_pix = taps[MID];
            TRIM_LATE1:  main_pix = taps[MID+1];
            TRIM_EARLY2: main_pix = taps[MID-2];
            default:     main_pix = taps[MID-1];
        endcase
        sum = acc_t'(main_pix) + scaled;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q  <= 1'b0;
            ov_q  <= 1'b0;
            out_q <= '0;
        end else begin
            v1_q <= in_valid;
            ov_q <= v1_q;
            if (v1_q) out_q <= sat_out(sum);
        end
    end

    assign out_valid = ov_q;
    assign out_luma  = out_q;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2)); // R2

    AST_CORE_PASS: assert property (@(posedge clk) disable iff (rst)
        (cored == acc_t'(0)) || (cored == detail)); // R6

    AST_ZERO_BOOST: assert property (@(posedge clk) disable iff (rst)
        (v1_q && scaled == acc_t'(0)) |=> ($signed(out_luma) == out_t'($past(main_pix)))); // R10

    AST_SCALE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (cored >= acc_t'(0)) |-> (scaled >= acc_t'(0))); // R7

endmodule

// File: tb/luma_peaking_core_tb_top.sv
module luma_peaking_core_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_luma = '0;
    logic [1:0] cfg_band = '0;
    logic cfg_bypass = 1'b0;
    logic cfg_alt = 1'b0;
    logic [1:0] cfg_gain = '0;
    logic [1:0] cfg_core = '0;
    logic [1:0] cfg_trim = '0;
    logic out_valid;
    logic signed [8:0] out_luma;

    int n_total = 0;
    int n_fail = 0;
    int h [5];
    logic vq [2];
    int eq [2];
    int cur_exp = 0;

    always #10 clk = ~clk;

    luma_peaking_core dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_luma(in_luma),
        .cfg_band(cfg_band), .cfg_bypass(cfg_bypass), .cfg_alt(cfg_alt),
        .cfg_gain(cfg_gain), .cfg_core(cfg_core), .cfg_trim(cfg_trim),
        .out_valid(out_valid), .out_luma(out_luma)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model();
        int e1, e2, e4, d, thr, mag, sc, mn, s, code;
        e1 = 2*h[2] - h[1] - h[3];
        e2 = 2*h[2] - h[0] - h[4];
        e4 = 4*h[2] - h[0] - h[1] - h[3] - h[4];
        if (cfg_bypass) d = cfg_alt ? (e4 >>> 3) : (e2 >>> 2);  // R5
        else begin                                                 // R4
            case (cfg_band)
                2'd0: d = e1 >>> 1;
                2'd1: d = e2 >>> 1;
                2'd2: d = e4 >>> 2;
                default: d = e1;
            endcase
        end
        thr = (cfg_core == 0) ? 0 : (cfg_core == 1) ? 2 : (cfg_core == 2) ? 4 : 8; // R6
        mag = (d < 0) ? -d : d;
        if (mag <= thr) d = 0;
        code = {cfg_bypass, cfg_gain};                             // R7
        case (code)
            0: sc = d >>> 3;
            1: sc = d >>> 2;
            2: sc = d >>> 1;
            3: sc = d;
            4: sc = 0;
            5: sc = d >>> 2;
            6: sc = d >>> 1;
            default: sc = d;
        endcase
        case (cfg_trim)                                            // R8
            2'd0: mn = h[2];
            2'd1: mn = h[3];
            2'd2: mn = h[0];
            default: mn = h[1];
        endcase
        s = mn + sc;                                               // R10
        if (s > 255) s = 255;                                      // R9
        if (s < -256) s = -256;
        return s;
    endfunction

    task automatic step(input logic v, input int pix);
        @(negedge clk);
        chk(int'(out_valid), int'(vq[1]), "R2 R3 output valid timing");
        if (vq[1]) cur_exp = eq[1];
        chk(int'(out_luma), cur_exp,
            vq[1] ? "R4 R5 R6 R7 R8 R9 R10 datapath" : "R3 hold on idle");
        vq[1] = vq[0];
        eq[1] = eq[0];
        vq[0] = v;
        if (v) begin
            for (int k = 4; k > 0; k--) h[k] = h[k-1];
            h[0] = pix;
            eq[0] = model();
        end
        in_valid = v;
        in_luma  = pix[7:0];
    endtask

    function automatic int gen_pix(input int mode, input int i);
        case (mode)
            0: return int'($urandom_range(255)) - 128;
            1: return ($urandom_range(1) != 0) ? 127 : -128;
            2: return 40 + int'($urandom_range(18)) - 9;
            default: return (i < 4) ? -100 : 100;
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_total++;
        $display("FAIL watchdog R2: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int cidx;
        for (int k = 0; k < 5; k++) h[k] = 0;
        vq[0] = 1'b0; vq[1] = 1'b0; eq[0] = 0; eq[1] = 0;
        repeat (3) @(negedge clk);
        chk(int'(out_valid), 0, "R1 reset valid");
        chk(int'(out_luma), 0, "R1 reset luma");
        rst = 1'b0;
        @(negedge clk);
        chk(int'(out_valid), 0, "R1 valid after release");
        chk(int'(out_luma), 0, "R1 luma after release");
        cidx = 0;
        for (int byp = 0; byp < 2; byp++)
        for (int alt = 0; alt < 2; alt++)
        for (int band = 0; band < 4; band++)
        for (int gn = 0; gn < 4; gn++)
        for (int cr = 0; cr < 4; cr++)
        for (int tr = 0; tr < 4; tr++) begin
            int mode;
            cfg_bypass = byp[0]; cfg_alt = alt[0]; cfg_band = band[1:0];
            cfg_gain = gn[1:0]; cfg_core = cr[1:0]; cfg_trim = tr[1:0];
            mode = cidx % 4;
            for (int i = 0; i < 8; i++) begin
                logic v;
                v = (mode == 3) ? 1'b1 : ($urandom_range(3) != 0);
                step(v, gen_pix(mode, i));
            end
            step(1'b0, 0);
            step(1'b0, 0);
            cidx++;
        end
        step(1'b0, 0);
        step(1'b0, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule